// File: doc/BRIEF.md
# SDRAM Mode Register Load Checker

This block models, on the device side, the mode-register logic of a double-data-rate SDRAM. It watches a decoded command interface: a register-load strobe, two bank-select bits, the address bus, a flag that says every bank is idle, a flag that says a burst is running, and a strobe for any other command. It holds the base mode register and turns its fields into ready-to-use outputs: burst length in beats, a burst-order flag, and CAS latency in half-cycle units.

A load with bank bits `00` writes the base register. A load with bank bits `01` goes to the extended register, whose contents are kept elsewhere; here it only starts the hold-off window. The block raises one-cycle flags for reserved field values, for loads issued while banks are busy or a burst is running, and for commands issued inside the hold-off window after a load. A rejected load leaves the stored register as it was. A request for a delay-locked-loop reset comes out as a single-cycle pulse and is never kept in the stored word.

Top module: `modeRegCheck`

## Requirements
- R1: After a synchronous reset, `modeWord`, `burstLen`, `casX2` and `burstInterleaved` are 0, `notConfigured` is 1, and `dllResetPulse`, `protoErr`, `reservedErr` and `gapErr` are 0.
- R2: A load writes the base register only when `bankAddr` is `00`. With `bankAddr` `01` the base register is left unchanged. Any load with `bankAddr[1]`=1 raises `reservedErr` and changes nothing.
- R3: `addrBus[2:0]` selects the burst length: 001 gives `burstLen`=2, 010 gives 4 and 011 gives 8. Any other value raises `reservedErr` and the load is rejected.
- R4: `addrBus[3]` is stored as the burst order: 0 gives `burstInterleaved`=0 (sequential) and 1 gives `burstInterleaved`=1 (interleaved).
- R5: `addrBus[6:4]` selects the CAS latency, shown as `casX2` (twice the latency): 010 gives 4, 011 gives 6 and 110 gives 5. Any other value raises `reservedErr` and the load is rejected.
- R6: `addrBus[7]` and every bit above bit 8 must be 0, or the load raises `reservedErr` and is rejected. An accepted base load with `addrBus[8]`=1 produces `dllResetPulse` high for exactly one cycle, and `modeWord[8]` always reads 0.
- R7: A load issued while `allIdle`=0 or `burstActive`=1 raises `protoErr` and leaves the base register unchanged.
- R8: After an accepted load of either register, any command (`lmrCmd` or `cmdValid`) issued fewer than `GAP_CYC` cycles later raises `gapErr`, and a load issued in that window is not applied. The default `GAP_CYC` is 2, so only the cycle right after the load is blocked.
- R9: `notConfigured` falls at the first accepted base load and stays low until reset.
- R10: All outputs change on the clock edge that samples the command. The error flags and `dllResetPulse` are one-cycle pulses. Apart from an accepted base load, nothing changes `modeWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lmrCmd | input | 1 | Register-load command strobe |
| bankAddr | input | 2 | Bank-select bits that pick the target register |
| addrBus | input | ADDR_W | Address bus carrying the register value |
| allIdle | input | 1 | High when every bank is idle |
| burstActive | input | 1 | High while a read or write burst is running |
| cmdValid | input | 1 | Strobe for any other command |
| modeWord | output | ADDR_W | Stored base register, bit 8 always 0 |
| burstLen | output | 4 | Burst length in beats (0 until configured) |
| burstInterleaved | output | 1 | 1 for interleaved order, 0 for sequential |
| casX2 | output | 4 | CAS latency times two (0 until configured) |
| dllResetPulse | output | 1 | One-cycle delay-locked-loop reset request |
| notConfigured | output | 1 | High until the first accepted base load |
| protoErr | output | 1 | Pulse: load issued while banks were busy or a burst was running |
| reservedErr | output | 1 | Pulse: load carried a reserved value or reserved bank bits |
| gapErr | output | 1 | Pulse: command issued inside the hold-off window |

## Verification
Every result is due on the first rising edge after the cycle in which the command is presented: the stored word and its decoded fields, the reset pulse and all three error flags. The hold-off window counts from that same edge. The bench changes inputs on the falling edge. It updates its reference model once per rising edge and compares every output 2 ns after that edge, so each comparison sees the edge that consumed the command and never the next one. The reset pulse and the error flags are checked both in the cycle they rise and in the cycle after, which shows they are exactly one cycle wide.

// File: rtl/modeRegPkg.sv
package modeRegPkg;

  typedef struct packed {
    logic loadBase;
    logic dllReq;
    logic protoErr;
    logic reservedErr;
    logic gapErr;
  } ctlStrobesT;

  function automatic logic blLegal(input logic [2:0] f);
    return (f == 3'b001) || (f == 3'b010) || (f == 3'b011);
  endfunction

  function automatic logic clLegal(input logic [2:0] f);
    return (f == 3'b010) || (f == 3'b011) || (f == 3'b110);
  endfunction

endpackage

// File: rtl/modeRegCtrl.sv
module modeRegCtrl
  import modeRegPkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lmrCmd,
  input  logic [1:0]        bankAddr,
  input  logic [2:0]        blField,
  input  logic [2:0]        clField,
  input  logic [ADDR_W-8:0] opField,
  input  logic              allIdle,
  input  logic              burstActive,
  input  logic              cmdValid,
  output ctlStrobesT        strobes
);
  localparam int HOLD = GAP_CYC - 1;

  logic holdBusy;
  logic stateBad, gapHit, fieldBad, opBad, resHit, accept;

  always_comb begin
    opBad    = opField[0] || (|opField[ADDR_W-8:2]);
    fieldBad = !blLegal(blField) || !clLegal(clField) || opBad;
    stateBad = lmrCmd && (!allIdle || burstActive);
    gapHit   = (lmrCmd || cmdValid) && holdBusy;
    resHit   = lmrCmd && (bankAddr[1] || ((bankAddr == 2'b00) && fieldBad));
    accept   = lmrCmd && !stateBad && !gapHit && !resHit;

    strobes.loadBase    = accept && (bankAddr == 2'b00);
    strobes.dllReq      = accept && (bankAddr == 2'b00) && opField[1];
    strobes.protoErr    = stateBad;
    strobes.reservedErr = resHit;
    strobes.gapErr      = gapHit;
  end

  generate
    if (HOLD <= 0) begin : g_noHold
      assign holdBusy = 1'b0;
    end else begin : g_hold
      localparam int HOLD_W = $clog2(HOLD + 1);
      logic [HOLD_W-1:0] holdCnt;
      always_ff @(posedge clk) begin
        if (rst)              holdCnt <= '0;
        else if (accept)      holdCnt <= HOLD_W'(HOLD);
        else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
      end
      assign holdBusy = (holdCnt != 0);
    end
  endgenerate

endmodule

// File: rtl/modeRegData.sv
module modeRegData
  import modeRegPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobesT        strobes,
  input  logic [ADDR_W-1:0] addrBus,
  output logic [ADDR_W-1:0] modeWord,
  output logic [3:0]        burstLen,
  output logic              burstInterleaved,
  output logic [3:0]        casX2,
  output logic              dllResetPulse,
  output logic              notConfigured,
  output logic              protoErr,
  output logic              reservedErr,
  output logic              gapErr
);
  localparam logic [ADDR_W-1:0] SELF_CLR = ADDR_W'(1) << 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeWord      <= '0;
      notConfigured <= 1'b1;
      dllResetPulse <= 1'b0;
      protoErr      <= 1'b0;
      reservedErr   <= 1'b0;
      gapErr        <= 1'b0;
    end else begin
      if (strobes.loadBase) begin
        modeWord      <= addrBus & ~SELF_CLR;
        notConfigured <= 1'b0;
      end
      dllResetPulse <= strobes.dllReq;
      protoErr      <= strobes.protoErr;
      reservedErr   <= strobes.reservedErr;
      gapErr        <= strobes.gapErr;
    end
  end

  always_comb begin
    case (modeWord[2:0])
      3'b001:  burstLen = 4'd2;
      3'b010:  burstLen = 4'd4;
      3'b011:  burstLen = 4'd8;
      default: burstLen = 4'd0;
    endcase
    case (modeWord[6:4])
      3'b010:  casX2 = 4'd4;
      3'b011:  casX2 = 4'd6;
      3'b110:  casX2 = 4'd5;
      default: casX2 = 4'd0;
    endcase
    burstInterleaved = modeWord[3];
  end

endmodule

// File: rtl/modeRegCheck.sv
module modeRegCheck
  import modeRegPkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lmrCmd,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic              allIdle,
  input  logic              burstActive,
  input  logic              cmdValid,
  output logic [ADDR_W-1:0] modeWord,
  output logic [3:0]        burstLen,
  output logic              burstInterleaved,
  output logic [3:0]        casX2,
  output logic              dllResetPulse,
  output logic              notConfigured,
  output logic              protoErr,
  output logic              reservedErr,
  output logic              gapErr
);
  ctlStrobesT strobes;

  modeRegCtrl #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .lmrCmd(lmrCmd), .bankAddr(bankAddr),
    .blField(addrBus[2:0]), .clField(addrBus[6:4]),
    .opField(addrBus[ADDR_W-1:7]),
    .allIdle(allIdle), .burstActive(burstActive), .cmdValid(cmdValid),
    .strobes(strobes)
  );

  modeRegData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .addrBus(addrBus),
    .modeWord(modeWord), .burstLen(burstLen),
    .burstInterleaved(burstInterleaved), .casX2(casX2),
    .dllResetPulse(dllResetPulse), .notConfigured(notConfigured),
    .protoErr(protoErr), .reservedErr(reservedErr), .gapErr(gapErr)
  );

endmodule

// File: rtl/modeRegCheckSva.sv
module modeRegCheckSva #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              lmrCmd,
  input logic [1:0]        bankAddr,
  input logic              allIdle,
  input logic              burstActive,
  input logic [ADDR_W-1:0] modeWord,
  input logic [3:0]        burstLen,
  input logic              dllResetPulse,
  input logic              notConfigured
);
  a_r6_dll_one_wide: assert property (@(posedge clk) disable iff (rst)
    dllResetPulse |=> !dllResetPulse);

  a_r6_bit8_never_kept: assert property (@(posedge clk) disable iff (rst)
    !modeWord[8]);

  a_r7_busy_load: assert property (@(posedge clk) disable iff (rst)
    lmrCmd && (!allIdle || burstActive) |=> $stable(modeWord));

  a_r2_bank_hi: assert property (@(posedge clk) disable iff (rst)
    lmrCmd && bankAddr[1] |=> $stable(modeWord) && !dllResetPulse);

  a_r10_no_load_stable: assert property (@(posedge clk) disable iff (rst)
    !lmrCmd |=> $stable(modeWord) && !dllResetPulse);

  a_r9_cfg_sticky: assert property (@(posedge clk) disable iff (rst)
    !notConfigured |=> !notConfigured);

  a_r3_len_set: assert property (@(posedge clk) disable iff (rst)
    !notConfigured |-> $onehot0(burstLen) && (burstLen != 4'd0) && !burstLen[0]);

endmodule

bind modeRegCheck modeRegCheckSva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .lmrCmd(lmrCmd), .bankAddr(bankAddr),
  .allIdle(allIdle), .burstActive(burstActive), .modeWord(modeWord),
  .burstLen(burstLen), .dllResetPulse(dllResetPulse),
  .notConfigured(notConfigured)
);

// File: tb/sim_modeRegCheck.sv
`timescale 1ns/1ps
module sim_modeRegCheck;
  localparam int AW  = 12;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lmrCmd = 0, allIdle = 1, burstActive = 0, cmdValid = 0;
  logic [1:0] bankAddr = 0;
  logic [AW-1:0] addrBus = 0;
  logic [AW-1:0] modeWord;
  logic [3:0] burstLen, casX2;
  logic burstInterleaved, dllResetPulse, notConfigured, protoErr, reservedErr, gapErr;

  always #4 clk = ~clk;

  modeRegCheck #(.ADDR_W(AW), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst(rst), .lmrCmd(lmrCmd), .bankAddr(bankAddr), .addrBus(addrBus),
    .allIdle(allIdle), .burstActive(burstActive), .cmdValid(cmdValid),
    .modeWord(modeWord), .burstLen(burstLen), .burstInterleaved(burstInterleaved),
    .casX2(casX2), .dllResetPulse(dllResetPulse), .notConfigured(notConfigured),
    .protoErr(protoErr), .reservedErr(reservedErr), .gapErr(gapErr)
  );

  int total = 0, bad = 0;
  int mWord = 0, mNc = 1, mDll = 0, mProto = 0, mRes = 0, mGap = 0, holdCnt = 0;

  function automatic int expLen(int w);
    case (w & 7) 1: return 2; 2: return 4; 3: return 8; default: return 0; endcase
  endfunction
  function automatic int expCas(int w);
    case ((w >> 4) & 7) 2: return 4; 3: return 6; 6: return 5; default: return 0; endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "modeWord", int'(modeWord), mWord);
    chk(tag, "burstLen", int'(burstLen), expLen(mWord));
    chk(tag, "casX2", int'(casX2), expCas(mWord));
    chk(tag, "burstInterleaved", int'(burstInterleaved), (mWord >> 3) & 1);
    chk(tag, "notConfigured", int'(notConfigured), mNc);
    chk(tag, "dllResetPulse", int'(dllResetPulse), mDll);
    chk(tag, "protoErr", int'(protoErr), mProto);
    chk(tag, "reservedErr", int'(reservedErr), mRes);
    chk(tag, "gapErr", int'(gapErr), mGap);
  endtask

  // One cycle: drive at the falling edge, model at the rising edge, compare 2 ns later.
  task automatic step(bit lmr, int ba, int addr, bit idle, bit burst, bit cmd, string tag);
    int bl, cl;
    bit legal, busy, acc;
    lmrCmd = lmr; bankAddr = 2'(ba); addrBus = AW'(addr);
    allIdle = idle; burstActive = burst; cmdValid = cmd;
    @(posedge clk);
    bl = addr & 7; cl = (addr >> 4) & 7;
    legal = (bl >= 1 && bl <= 3) && (cl == 2 || cl == 3 || cl == 6) &&
            ((addr >> 7) & 1) == 0 && (addr >> 9) == 0;
    busy   = holdCnt > 0;
    mProto = lmr && (!idle || burst);
    mGap   = (lmr || cmd) && busy;
    mRes   = lmr && ((ba >> 1) != 0 || (ba == 0 && !legal));
    acc    = lmr && !mProto && !mGap && !mRes;
    mDll   = 0;
    if (acc) holdCnt = GAP - 1; else if (holdCnt > 0) holdCnt--;
    if (acc && ba == 0) begin
      mWord = addr & ~(1 << 8);
      mNc   = 0;
      mDll  = (addr >> 8) & 1;
    end
    #2 compareAll(tag);
    @(negedge clk);
  endtask

  task automatic idle1(string tag);
    step(0, 0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #2 compareAll("R1");          // reset state
    idle1("R1");
    // R3/R5 burst length 4, CAS 2, sequential
    step(1, 0, 'h022, 1, 0, 0, "R3");
    idle1("R4");
    // R4/R6 BL8 interleaved CL3 with DLL reset
    step(1, 0, 'h13B, 1, 0, 0, "R6");
    idle1("R6");                   // pulse gone, bit8 cleared
    // R8 back-to-back: command and load inside window
    step(1, 0, 'h061, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 1, "R8");
    step(1, 0, 'h022, 1, 0, 0, "R8");
    step(1, 0, 'h022, 1, 0, 0, "R8");
    step(1, 0, 'h022, 1, 0, 0, "R8");
    idle1("R8");
    // R3 reserved lengths
    step(1, 0, 'h020, 1, 0, 0, "R3");
    step(1, 0, 'h024, 1, 0, 0, "R3");
    step(1, 0, 'h027, 1, 0, 0, "R3");
    // R5 reserved CAS values and 2.5
    step(1, 0, 'h012, 1, 0, 0, "R5");
    step(1, 0, 'h042, 1, 0, 0, "R5");
    step(1, 0, 'h072, 1, 0, 0, "R5");
    step(1, 0, 'h069, 1, 0, 0, "R5");
    idle1("R5");
    // R6 operating-mode reserved bits
    step(1, 0, 'h0A2, 1, 0, 0, "R6");
    step(1, 0, 'h222, 1, 0, 0, "R6");
    step(1, 0, 'h822, 1, 0, 0, "R6");
    step(1, 0, 'h1A2, 1, 0, 0, "R6");
    // R2 bank targets
    step(1, 1, 'h033, 1, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(1, 2, 'h033, 1, 0, 0, "R2");
    step(1, 3, 'h033, 1, 0, 0, "R2");
    // R7 busy state
    step(1, 0, 'h033, 0, 0, 0, "R7");
    step(1, 0, 'h033, 1, 1, 0, "R7");
    step(1, 0, 'h133, 0, 1, 0, "R7");
    // R10 commands other than loads leave state alone
    step(0, 0, 'h1FF, 1, 0, 1, "R10");
    step(0, 0, 'h1FF, 1, 0, 1, "R10");
    // R9 further loads keep notConfigured low, BL2
    step(1, 0, 'h031, 1, 0, 0, "R9");
    idle1("R9");
    step(1, 0, 'h13A, 1, 0, 0, "R6");
    idle1("R6");
    // R1 reset again restores defaults
    rst = 1;
    @(posedge clk);
    mWord = 0; mNc = 1; mDll = 0; mProto = 0; mRes = 0; mGap = 0; holdCnt = 0;
    #2 compareAll("R1");
    @(negedge clk);
    rst = 0;
    idle1("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule